// File: doc/BRIEF.md
# DRAM Refresh and Initialisation Scheduler

This block keeps a 256-row dynamic RAM alive. After reset it owns the RAS and CAS strobes. It waits out the power-up pause, then runs a fixed number of wake-up refresh cycles back to back. Only then does it clear its busy flag and hand the strobes to the access controller.

In normal operation a free-running interval timer adds one owed refresh each period, which is about 15.6 µs so that all rows are covered within 4 ms. The owed count saturates at a small limit. While anything is owed, the block raises a request. A grant from the controller lets it run one CAS-before-RAS cycle on the strobes, followed by the precharge time, after which it hands the strobes back. A backlog is therefore worked off in consecutive granted cycles without cutting into any access.

A held sleep input also raises the request. Once granted, the block enters self refresh: a CAS-before-RAS entry with RAS held low for at least the minimum self-refresh time and for as long as sleep stays high. It leaves self refresh by raising RAS and observing the longer exit precharge.

Top module: `dram_refresh_sched`

## Requirements
- R1: During reset and after reset release, `rasN` and `casN` are high, `busy` is high and `refReq` is low. The first falling edge of `casN` is sampled exactly `PWR_CYC` clock cycles after the first rising clock edge with reset released.
- R2: Every refresh is CAS-before-RAS. `casN` falls while `rasN` is high, exactly one cycle before `rasN` falls. Both stay low for exactly `RAS_CYC` cycles in a normal refresh, and both rise in the same cycle.
- R3: Between a normal refresh's `rasN` rise and the next `casN` fall or the release of the strobes, both strobes are high for at least `RP_CYC` cycles. The release happens exactly `RP_CYC` cycles after the rise.
- R4: Initialisation runs exactly `WAKE_CNT` refresh cycles back to back without any grant, and `refReq` stays low while `busy` is high. `busy` falls exactly `PWR_CYC + WAKE_CNT*(1+RAS_CYC+RP_CYC)` cycles after reset release.
- R5: The owed count rises by one every `REFI_CYC` cycles counted from reset release, saturating at `MAX_OWED`. It is cleared when initialisation ends. While the block is idle, `refReq` is high exactly when something is owed or `sleepReq` is high.
- R6: `refReq` is held until granted. A grant sampled while `refReq` is high starts a cycle at that edge: in the next cycle `refReq` is low, `ownStrobes` is high and `casN` is low.
- R7: A grant while `refReq` is low has no effect: `ownStrobes` stays low.
- R8: Each granted normal refresh reduces the owed count by one. With the grant held high, a backlog is performed in consecutive cycles.
- R9: A grant taken while `sleepReq` is high enters self refresh. `rasN` stays low for at least `SREF_CYC` cycles and for as long as `sleepReq` stays high.
- R10: Self refresh ends on the first edge at which the minimum time has elapsed and `sleepReq` is low: `rasN` rises at that edge. The strobes are released exactly `RPS_CYC` cycles later, and the owed count is cleared at the rise.
- R11: `ownStrobes` is high whenever either strobe is low, and it is low when the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepReq | input | 1 | Held high to request self refresh |
| grant | input | 1 | Controller permits the pending request |
| refReq | output | 1 | Refresh or self-refresh entry pending |
| busy | output | 1 | High until initialisation finishes |
| ownStrobes | output | 1 | Block is driving the DRAM strobes |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |

## Verification
The grant is withheld for a swept number of refresh intervals, from zero to beyond saturation, before it is held high. This separates immediate service, a partial backlog and a saturated backlog, and an arithmetic model of the owed count predicts the request on every cycle.

Self refresh is exercised three ways:
- Sleep dropped before the minimum time, which tells the minimum hold apart from sleep tracking.
- Sleep held long past the minimum.
- Sleep raised on top of a pending backlog, which shows that exit clears the debt.

A grant held while nothing is pending confirms that it is ignored.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

  typedef enum logic [2:0] {
    ST_PWR, ST_CSR, ST_RAS, ST_PRE, ST_IDLE, ST_SCSR, ST_SRAS, ST_SPRE
  } refState_e;

  typedef enum logic [1:0] {LD_RAS, LD_PRE, LD_SREF, LD_SPRE} ldSel_e;

  typedef struct packed {
    logic   ldCnt;
    ldSel_e ldSel;
    logic   wakeDec;
    logic   owedDec;
    logic   owedClr;
  } ctlStrobe_t;

endpackage

// File: rtl/refsched_timers.sv
module refsched_timers
  import refsched_pkg::*;
#(
  parameter int PWR_CYC  = 10000,
  parameter int REFI_CYC = 780,
  parameter int RAS_CYC  = 3,
  parameter int RP_CYC   = 2,
  parameter int SREF_CYC = 15000,
  parameter int RPS_CYC  = 3,
  parameter int WAKE_CNT = 8,
  parameter int MAX_OWED = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  ctlStrobe_t ctl,
  output logic       cntZero,
  output logic       wakeLast,
  output logic       owedPend
);
  localparam int M1   = (PWR_CYC > SREF_CYC) ? PWR_CYC : SREF_CYC;
  localparam int M2   = (RAS_CYC > RP_CYC) ? RAS_CYC : RP_CYC;
  localparam int M3   = (M2 > RPS_CYC) ? M2 : RPS_CYC;
  localparam int MAXP = (M1 > M3) ? M1 : M3;
  localparam int CW   = $clog2(MAXP + 1);
  localparam int TW   = $clog2(REFI_CYC + 1);
  localparam int WW   = $clog2(WAKE_CNT + 1);
  localparam int OW   = $clog2(MAX_OWED + 1);

  logic [CW-1:0] phaseCnt, ldVal;
  logic [TW-1:0] refiCnt;
  logic [WW-1:0] wakeLeft;
  logic [OW-1:0] owed;
  logic          tick;

  always_comb begin
    case (ctl.ldSel)
      LD_RAS:  ldVal = CW'(RAS_CYC - 1);
      LD_PRE:  ldVal = CW'(RP_CYC - 1);
      LD_SREF: ldVal = CW'(SREF_CYC - 1);
      default: ldVal = CW'(RPS_CYC - 1);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                phaseCnt <= CW'(PWR_CYC - 1);
    else if (ctl.ldCnt)       phaseCnt <= ldVal;
    else if (phaseCnt != '0)  phaseCnt <= phaseCnt - 1'b1;
  end
  assign cntZero = (phaseCnt == '0);

  assign tick = (refiCnt == TW'(REFI_CYC - 1));
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     refiCnt <= '0;
    else if (tick) refiCnt <= '0;
    else           refiCnt <= refiCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wakeLeft <= WW'(WAKE_CNT);
    else if (ctl.wakeDec) wakeLeft <= wakeLeft - 1'b1;
  end
  assign wakeLast = (wakeLeft == WW'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                              owed <= '0;
    else if (ctl.owedClr)                   owed <= '0;
    else if (tick && !ctl.owedDec) begin
      if (owed != OW'(MAX_OWED))            owed <= owed + 1'b1;
    end
    else if (ctl.owedDec && !tick)          owed <= owed - 1'b1;
  end
  assign owedPend = (owed != '0);

  // R5: saturation holds the count at its limit
  p_owed_sat_r5: assert property (@(posedge clk) disable iff (!rstN)
    (owed == OW'(MAX_OWED) && tick && !ctl.owedDec && !ctl.owedClr) |=> owed == OW'(MAX_OWED));
  // R4: never count past the last wake-up cycle
  p_wake_dec_r4: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wakeDec |-> wakeLeft != '0);
  // R8: a refresh is only consumed when one is owed
  p_owed_dec_r8: assert property (@(posedge clk) disable iff (!rstN)
    ctl.owedDec |-> owedPend);

endmodule

// File: rtl/refsched_ctrl.sv
module refsched_ctrl
  import refsched_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sleepReq,
  input  logic       grant,
  input  logic       cntZero,
  input  logic       wakeLast,
  input  logic       owedPend,
  output ctlStrobe_t ctl,
  output logic       refReq,
  output logic       busy,
  output logic       ownStrobes,
  output logic       rasN,
  output logic       casN
);
  refState_e state, stateNxt;
  logic      initDone, initDoneNxt;

  assign refReq     = (state == ST_IDLE) && (owedPend || sleepReq);
  assign busy       = !initDone;
  assign ownStrobes = (state != ST_IDLE);
  assign casN = !(state inside {ST_CSR, ST_RAS, ST_SCSR, ST_SRAS});
  assign rasN = !(state inside {ST_RAS, ST_SRAS});

  always_comb begin
    stateNxt    = state;
    initDoneNxt = initDone;
    ctl         = '{ldCnt: 1'b0, ldSel: LD_RAS, wakeDec: 1'b0, owedDec: 1'b0, owedClr: 1'b0};
    case (state)
      ST_PWR:  if (cntZero) stateNxt = ST_CSR;
      ST_CSR:  begin stateNxt = ST_RAS; ctl.ldCnt = 1'b1; ctl.ldSel = LD_RAS; end
      ST_RAS:  if (cntZero) begin stateNxt = ST_PRE; ctl.ldCnt = 1'b1; ctl.ldSel = LD_PRE; end
      ST_PRE:  if (cntZero) begin
                 if (!initDone) begin
                   ctl.wakeDec = 1'b1;
                   if (wakeLast) begin
                     initDoneNxt = 1'b1; ctl.owedClr = 1'b1; stateNxt = ST_IDLE;
                   end else stateNxt = ST_CSR;
                 end else stateNxt = ST_IDLE;
               end
      ST_IDLE: if (refReq && grant) begin
                 if (sleepReq) stateNxt = ST_SCSR;
                 else begin stateNxt = ST_CSR; ctl.owedDec = 1'b1; end
               end
      ST_SCSR: begin stateNxt = ST_SRAS; ctl.ldCnt = 1'b1; ctl.ldSel = LD_SREF; end
      ST_SRAS: if (cntZero && !sleepReq) begin
                 stateNxt = ST_SPRE; ctl.ldCnt = 1'b1; ctl.ldSel = LD_SPRE; ctl.owedClr = 1'b1;
               end
      ST_SPRE: if (cntZero) stateNxt = ST_IDLE;
      default: stateNxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_PWR;
      initDone <= 1'b0;
    end else begin
      state    <= stateNxt;
      initDone <= initDoneNxt;
    end
  end

  p_cbr_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rasN) |-> !$past(casN));
  p_cas_first_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(casN) |-> rasN);
  p_busy_noreq_r4: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !refReq);
  p_req_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !grant && !sleepReq && owedPend) |=> refReq);
  p_grant_start_r6: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && grant) |=> (!refReq && !casN && ownStrobes));
  p_self_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN && state == ST_SRAS && sleepReq) |=> !rasN);
  p_own_strobe_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!rasN || !casN) |-> ownStrobes);

endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import refsched_pkg::*;
#(
  parameter int PWR_CYC  = 10000,
  parameter int REFI_CYC = 780,
  parameter int RAS_CYC  = 3,
  parameter int RP_CYC   = 2,
  parameter int SREF_CYC = 15000,
  parameter int RPS_CYC  = 3,
  parameter int WAKE_CNT = 8,
  parameter int MAX_OWED = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic sleepReq,
  input  logic grant,
  output logic refReq,
  output logic busy,
  output logic ownStrobes,
  output logic rasN,
  output logic casN
);
  ctlStrobe_t ctl;
  logic cntZero, wakeLast, owedPend;

  refsched_timers #(
    .PWR_CYC(PWR_CYC), .REFI_CYC(REFI_CYC), .RAS_CYC(RAS_CYC), .RP_CYC(RP_CYC),
    .SREF_CYC(SREF_CYC), .RPS_CYC(RPS_CYC), .WAKE_CNT(WAKE_CNT), .MAX_OWED(MAX_OWED)
  ) uTimers (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .cntZero(cntZero), .wakeLast(wakeLast), .owedPend(owedPend)
  );

  refsched_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .grant(grant),
    .cntZero(cntZero), .wakeLast(wakeLast), .owedPend(owedPend),
    .ctl(ctl), .refReq(refReq), .busy(busy), .ownStrobes(ownStrobes),
    .rasN(rasN), .casN(casN)
  );

endmodule

// File: tb/sim_dram_refresh_sched.sv
`timescale 1ns/1ps
module sim_dram_refresh_sched;
  localparam int PWR = 20, REFI = 40, RASC = 3, RPC = 2, SREF = 10, RPSC = 3, WAKE = 8, MAXO = 3;

  logic clk = 1'b0, rstN = 1'b0, sleepReq = 1'b0, grant = 1'b0;
  logic refReq, busy, ownStrobes, rasN, casN;
  int compared = 0, mismatched = 0, posCnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dram_refresh_sched #(.PWR_CYC(PWR), .REFI_CYC(REFI), .RAS_CYC(RASC), .RP_CYC(RPC),
    .SREF_CYC(SREF), .RPS_CYC(RPSC), .WAKE_CNT(WAKE), .MAX_OWED(MAXO)) u0 (
    .clk(clk), .rstN(rstN), .sleepReq(sleepReq), .grant(grant), .refReq(refReq),
    .busy(busy), .ownStrobes(ownStrobes), .rasN(rasN), .casN(casN));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, posCnt, act, exp);
    end
  endtask

  task automatic step(input int k);
    repeat (k) @(posedge clk);
    #5;
  endtask

  always @(posedge clk) if (rstN) posCnt++;

  // Arithmetic model and protocol monitor, sampled at the falling edge
  int  mOwed = 0, lowRun = 0, sinceRise = 0, wakeFalls = 0;
  bit  pRas = 1, pCas = 1, pOwn = 1, pBusy = 1, pReq = 0, pGrant = 0, pSleep = 0;
  bit  selfMode = 0, firstCas = 0, riseSeen = 0;

  always @(negedge clk) if (rstN) begin
    automatic int  n    = posCnt;
    automatic bit  tick = (n % REFI == 0);
    automatic bit  acc  = pReq && pGrant && !pOwn;
    automatic bit  dec  = acc && !pSleep;
    if (tick && !dec)      mOwed = (mOwed < MAXO) ? mOwed + 1 : MAXO;
    else if (dec && !tick) mOwed = mOwed - 1;
    if ((pBusy && !busy) || (selfMode && !pRas && rasN)) mOwed = 0;

    if (acc) chk(ownStrobes && !refReq && !casN, "R6 grant starts cycle", {ownStrobes, refReq, casN}, 3'b100);
    else if (!pOwn && !pBusy && pGrant && !pReq) chk(!ownStrobes, "R7 grant ignored", ownStrobes, 0);
    if (acc && pSleep) selfMode = 1;

    if (!busy && !ownStrobes) chk(refReq == (mOwed > 0 || sleepReq), "R5 R8 request vs owed", refReq, (mOwed > 0 || sleepReq));
    else if (busy) chk(!refReq, "R4 no request while busy", refReq, 0);

    if (!rasN || !casN) chk(ownStrobes, "R11 ownership", ownStrobes, 1);
    if (pCas && !casN) begin
      chk(rasN, "R2 CAS falls first", rasN, 1);
      if (!firstCas) begin firstCas = 1; chk(n == PWR, "R1 pause length", n, PWR); end
      if (riseSeen) chk(sinceRise >= RPC, "R3 precharge before CAS", sinceRise, RPC);
    end
    if (pRas && !rasN) begin
      chk(!pCas && !casN, "R2 CBR order", pCas, 0);
      if (busy) wakeFalls++;
    end
    if (!pRas && rasN) begin
      if (selfMode) chk(lowRun >= SREF && !pSleep, "R9 R10 self refresh hold", lowRun, SREF);
      else chk(lowRun == RASC && casN, "R2 RAS width", lowRun, RASC);
    end
    if (selfMode && !pRas) begin
      if (pSleep) chk(!rasN, "R9 RAS held while sleep", rasN, 0);
      else if (lowRun >= SREF) chk(rasN, "R10 exit on wake", rasN, 1);
    end
    if (pOwn && !ownStrobes && riseSeen) begin
      chk(sinceRise == (selfMode ? RPSC : RPC), selfMode ? "R10 exit precharge" : "R3 release time",
          sinceRise, selfMode ? RPSC : RPC);
      selfMode = 0;
    end
    if (pBusy && !busy) begin
      chk(wakeFalls == WAKE, "R4 wake cycle count", wakeFalls, WAKE);
      chk(n == PWR + WAKE * (1 + RASC + RPC), "R4 busy release time", n, PWR + WAKE * (1 + RASC + RPC));
    end

    if (!rasN) lowRun++; else lowRun = 0;
    if (!pRas && rasN) begin sinceRise = 1; riseSeen = 1; end
    else if (rasN) sinceRise++;
    pRas = rasN; pCas = casN; pOwn = ownStrobes; pBusy = busy;
    pReq = refReq; pGrant = grant; pSleep = sleepReq;
  end

  task automatic summary;
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    step(3);
    chk(rasN && casN, "R1 strobes in reset", {rasN, casN}, 3);
    chk(busy && !refReq, "R1 busy in reset", {busy, refReq}, 2);
    rstN = 1'b1;
    step(1);
    chk(busy && !refReq && rasN && casN, "R1 after release", {busy, refReq, rasN, casN}, 4'b1011);
    while (busy) step(1);
    // R5 R8: sweep grant latency from none to past saturation
    for (int d = 0; d <= 5; d++) begin
      grant = 1'b0;
      step(d * REFI + 7);
      grant = 1'b1;
      step(MAXO * (2 + RASC + RPC) + 12);
      grant = 1'b0;
      step(3);
    end
    // R7: grant while nothing pending
    while (refReq || ownStrobes) begin grant = 1'b1; step(1); end
    grant = 1'b1; step(4); grant = 1'b0; step(2);
    // R9 R10: short sleep (minimum hold governs)
    sleepReq = 1'b1; grant = 1'b1;
    while (!ownStrobes) step(1);
    grant = 1'b0; step(3); sleepReq = 1'b0; step(SREF + 10);
    // R9 R10: long sleep (sleep governs)
    sleepReq = 1'b1; grant = 1'b1;
    while (!ownStrobes) step(1);
    grant = 1'b0; step(30); sleepReq = 1'b0; step(15);
    // R10: sleep on top of a backlog clears it
    grant = 1'b0; step(2 * REFI + 3);
    sleepReq = 1'b1; grant = 1'b1;
    while (!ownStrobes) step(1);
    grant = 1'b0; step(SREF + 4); sleepReq = 1'b0; step(8);
    grant = 1'b1; step(REFI + 10); grant = 1'b0; step(5);
    summary();
  end
endmodule